// File: doc/BRIEF.md
# Cache Cycle Classifier and Transfer Counter

This block sits in a memory bus controller next to a second-level cache controller. On each cycle start strobe it samples the attributes of the new bus cycle. These are memory or I/O, read or write, code or data, second-level cacheable and snoop writeback. It also samples the memory side's cacheability answer and read-only hint, the page-cache-disable and lock flags, the CPU-cacheable indication and the ready-source indication. From these it decides which kind of cycle is running.

It then loads two down-counters. One holds the number of CPU-side ready pulses still owed. The other holds the number of memory-side data transfers the cache data array still expects. Memory-side ready strobes and CPU-side acknowledges count them down. An end-of-cycle strobe clears the memory-side count at once. The block holds the cycle type for the whole cycle, reports when both sides have finished, and flags a new start strobe that arrives while a cycle is still open.

Top module: `cache_cycle_classifier`

## Requirements
- R1: The type encodings are IDLE=0, LFILL=1, L2FILL=2, NCRD=3, ALLOC=4, WRITE=5, REPL=6, SNPWB=7 and IO=8. An I/O or special cycle (`is_mem`=0, `snoop_wb`=0) is classed IO with 1 memory-side transfer and 1 CPU-side pulse.
- R2: A cacheable read that the CPU may cache is classed LFILL, with 4 CPU-side pulses and a full line of memory-side transfers. A cacheable read needs `l2_cache`=1, `mem_ken`=1, `locked`=0 and `pcd`=0. The CPU may cache it when `cpu_cache`=1 and the read is not read-only data.
- R3: A full line is 4 memory-side transfers when `line8`=0 and 8 when `line8`=1.
- R4: A read is classed NCRD with 1 and 1 transfers when `l2_cache`=0 (even if `mem_ken`=1), when `mem_ken`=0, when `locked`=1 or when `pcd`=1.
- R5: A snoop writeback (`snoop_wb`=1) is classed SNPWB and takes priority over every other attribute. A memory write with `l2_cache`=1 is classed REPL. Both get a full line and 0 CPU pulses. A memory write with `l2_cache`=0 is classed WRITE with 1 and 1.
- R6: A cacheable read is classed L2FILL, with a full line and 1 CPU pulse, in two cases. The first is `cpu_cache`=0 with `pcd`=0. The second is a data read (`is_code`=0) with `read_only`=1. A code read with `read_only`=1 stays LFILL.
- R7: When `rdy_src`=0 the CPU count loads as 0. A cacheable read with `rdy_src`=0 is classed ALLOC.
- R8: Each `mem_rdy` during a cycle takes one from a nonzero memory count. `mem_eoc` sets the count to 0 at once. Strobes after the count reaches 0 leave it at 0.
- R9: Each `cpu_ack` during a cycle takes one from a nonzero CPU count. Extra acknowledges are ignored.
- R10: `busy` is high while either count is nonzero, and `cyc_type` holds its value during that time. In the cycle after both counts reach 0, `done` pulses for one cycle and `cyc_type` returns to IDLE.
- R11: A `cyc_start` while `busy` is high is ignored and raises `proto_err` for the next cycle only.
- R12: After reset both counts are 0, `cyc_type` is IDLE, and `busy`, `done` and `proto_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Cycle start strobe |
| is_mem | input | 1 | 1 = memory cycle, 0 = I/O or special |
| is_write | input | 1 | 1 = write |
| is_code | input | 1 | 1 = code fetch |
| l2_cache | input | 1 | Second-level cacheable attribute |
| snoop_wb | input | 1 | Snoop writeback start |
| mem_ken | input | 1 | Memory-side cacheability answer |
| read_only | input | 1 | Read-only hint |
| locked | input | 1 | Locked cycle |
| pcd | input | 1 | Page cache disable |
| cpu_cache | input | 1 | CPU-cacheable indication |
| rdy_src | input | 1 | CPU-side ready pulses wanted |
| line8 | input | 1 | Static line length: 1 = 8 transfers |
| mem_rdy | input | 1 | Memory-side transfer strobe |
| mem_eoc | input | 1 | Memory-side end of cycle |
| cpu_ack | input | 1 | CPU-side ready pulse issued |
| cyc_type | output | 4 | Held cycle type |
| mem_left | output | 4 | Memory transfers remaining |
| cpu_left | output | 3 | CPU pulses remaining |
| busy | output | 1 | Cycle open |
| done | output | 1 | One-cycle end pulse |
| proto_err | output | 1 | Start while busy |

## Verification
The bench attacks the priority order of the attributes. A snoop writeback is raised together with I/O. A code read is marked read-only. A read keeps a positive memory answer while its second-level attribute is off. A priority slip would yield the wrong type and a count of 1 instead of a line.

Every case runs under both line lengths, so a design with a fixed burst length would show 4 where 8 is due. Streams of strobes that outlast the count, and an end-of-cycle strobe in mid-line, catch counters that wrap or only stop at zero. A start strobe issued mid-cycle checks that a design does not reload over a live cycle.

// File: rtl/cache_cycle_classifier.sv
module cache_cycle_classifier #(
  parameter int CPU_LINE   = 4,
  parameter int SHORT_LINE = 4,
  parameter int LONG_LINE  = 8,
  localparam int CW = $clog2(CPU_LINE + 1),
  localparam int MW = $clog2(LONG_LINE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          is_mem,
  input  logic          is_write,
  input  logic          is_code,
  input  logic          l2_cache,
  input  logic          snoop_wb,
  input  logic          mem_ken,
  input  logic          read_only,
  input  logic          locked,
  input  logic          pcd,
  input  logic          cpu_cache,
  input  logic          rdy_src,
  input  logic          line8,
  input  logic          mem_rdy,
  input  logic          mem_eoc,
  input  logic          cpu_ack,
  output logic [3:0]    cyc_type,
  output logic [MW-1:0] mem_left,
  output logic [CW-1:0] cpu_left,
  output logic          busy,
  output logic          done,
  output logic          proto_err
);
  localparam logic [3:0] T_IDLE = 4'd0, T_LFILL = 4'd1, T_L2FILL = 4'd2,
                         T_NCRD = 4'd3, T_ALLOC = 4'd4, T_WRITE = 4'd5,
                         T_REPL = 4'd6, T_SNPWB = 4'd7, T_IO = 4'd8;

  logic [MW-1:0] line_len, ld_mem, mem_nx;
  logic [CW-1:0] ld_cpu, cpu_nx;
  logic [3:0]    ld_type;
  logic          cacheable, load;

  assign line_len  = line8 ? MW'(LONG_LINE) : MW'(SHORT_LINE);
  assign cacheable = l2_cache && mem_ken && !locked && !pcd;
  assign busy      = (mem_left != '0) || (cpu_left != '0);
  assign load      = cyc_start && !busy;

  always_comb begin
    ld_type = T_NCRD;
    ld_mem  = MW'(1);
    ld_cpu  = CW'(1);
    if (snoop_wb) begin
      ld_type = T_SNPWB; ld_mem = line_len; ld_cpu = '0;
    end else if (!is_mem) begin
      ld_type = T_IO;
    end else if (is_write) begin
      if (l2_cache) begin
        ld_type = T_REPL; ld_mem = line_len; ld_cpu = '0;
      end else
        ld_type = T_WRITE;
    end else if (cacheable) begin
      ld_mem = line_len;
      if (!rdy_src) begin
        ld_type = T_ALLOC; ld_cpu = '0;
      end else if (cpu_cache && !(read_only && !is_code)) begin
        ld_type = T_LFILL; ld_cpu = CW'(CPU_LINE);
      end else
        ld_type = T_L2FILL;
    end
    if (!rdy_src) ld_cpu = '0;
  end

  always_comb begin
    mem_nx = mem_left;
    cpu_nx = cpu_left;
    if (mem_eoc)                       mem_nx = '0;
    else if (mem_rdy && mem_left != 0) mem_nx = mem_left - 1'b1;
    if (cpu_ack && cpu_left != 0)      cpu_nx = cpu_left - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_type  <= T_IDLE;
      mem_left  <= '0;
      cpu_left  <= '0;
      done      <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= cyc_start && busy;
      done      <= 1'b0;
      if (load) begin
        cyc_type <= ld_type;
        mem_left <= ld_mem;
        cpu_left <= ld_cpu;
      end else if (busy) begin
        mem_left <= mem_nx;
        cpu_left <= cpu_nx;
        if (mem_nx == '0 && cpu_nx == '0) begin
          done     <= 1'b1;
          cyc_type <= T_IDLE;
        end
      end
    end
  end

  assert_mem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_left <= MW'(LONG_LINE));
  assert_cpu_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_left <= CW'(CPU_LINE));
  assert_eoc_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_eoc |=> mem_left == '0);
  assert_mem_extra_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_left == '0 |=> mem_left == '0);
  assert_cpu_extra_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cpu_left == '0 |=> cpu_left == '0);
  assert_type_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(cyc_type)));
  assert_proto_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && busy |=> proto_err && !done);
  assert_no_rdysrc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && !busy && !rdy_src |=> cpu_left == '0);
endmodule

// File: tb/cache_cycle_classifier_tb.sv
module cache_cycle_classifier_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_start = 0, is_mem = 0, is_write = 0, is_code = 0, l2_cache = 0,
        snoop_wb = 0, mem_ken = 0, read_only = 0, locked = 0, pcd = 0,
        cpu_cache = 0, rdy_src = 0, line8 = 0, mem_rdy = 0, mem_eoc = 0, cpu_ack = 0;
  logic [3:0] cyc_type, mem_left;
  logic [2:0] cpu_left;
  logic busy, done, proto_err;

  int n_chk = 0, n_err = 0;
  int m_type = 0, m_mem = 0, m_cpu = 0, m_done = 0, m_err = 0;
  int nx_type = 0, nx_mem = 0, nx_cpu = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  cache_cycle_classifier u_dut (.*);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_type = 0; m_mem = 0; m_cpu = 0; m_done = 0; m_err = 0;
    end else begin
      automatic bit b = (m_mem != 0) || (m_cpu != 0);
      m_done = 0;
      m_err  = cyc_start && b;
      if (cyc_start && !b) begin
        m_type = nx_type; m_mem = nx_mem; m_cpu = nx_cpu;
      end else if (b) begin
        if (mem_eoc) m_mem = 0;
        else if (mem_rdy && m_mem > 0) m_mem--;
        if (cpu_ack && m_cpu > 0) m_cpu--;
        if (m_mem == 0 && m_cpu == 0) begin m_done = 1; m_type = 0; end
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    check("R10 type model", cyc_type, m_type);
    check("R8 mem model", mem_left, m_mem);
    check("R9 cpu model", cpu_left, m_cpu);
    check("R10 busy model", busy, (m_mem != 0) || (m_cpu != 0));
    check("R10 done model", done, m_done);
    check("R11 err model", proto_err, m_err);
  end

  task automatic start(input bit mm, wr, cd, l2, sw, kn, ro, lk, pd, cc, rs,
                       input int et, em, ec, input string tag);
    @(negedge clk);
    is_mem = mm; is_write = wr; is_code = cd; l2_cache = l2; snoop_wb = sw;
    mem_ken = kn; read_only = ro; locked = lk; pcd = pd; cpu_cache = cc; rdy_src = rs;
    nx_type = et; nx_mem = em; nx_cpu = ec;
    cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
    check({tag, " type"}, cyc_type, et);
    check({tag, " mem count"}, mem_left, em);
    check({tag, " cpu count"}, cpu_left, ec);
  endtask

  task automatic drain(input int mode);
    if (mode == 1) begin
      mem_rdy = 1; @(negedge clk); mem_rdy = 0;
      mem_eoc = 1; @(negedge clk); mem_eoc = 0;
      check("R8 eoc clears memory count", mem_left, 0);
    end
    if (mode == 2) begin
      snoop_wb = 1; cyc_start = 1;
      @(negedge clk);
      cyc_start = 0; snoop_wb = 0;
      check("R11 start while busy flagged", proto_err, 1);
      check("R11 start while busy ignored", cyc_type, nx_type);
    end
    mem_rdy = 1; cpu_ack = 1;
    repeat (11) @(negedge clk);
    mem_rdy = 0; cpu_ack = 0;
    check("R8 extra strobes ignored", mem_left, 0);
    check("R9 extra acks ignored", cpu_left, 0);
    check("R10 idle after cycle", cyc_type, 0);
  endtask

  initial begin
    #(20 * 20000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset type", cyc_type, 0);
    check("R12 reset mem", mem_left, 0);
    check("R12 reset cpu", cpu_left, 0);
    check("R12 reset flags", {busy, done, proto_err}, 0);
    rst_n = 1;
    cmp_on = 1;
    for (int l8 = 0; l8 < 2; l8++) begin
      automatic int L = l8 ? 8 : 4;
      line8 = l8[0];
      //      mem wr cd l2 sw kn ro lk pd cc rs
      start(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 8, 1, 1, "R1 io");          drain(0);
      start(0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 1, 7, L, 0, "R5 snoop wb");    drain(1);
      start(1, 0, 0, 1, 0, 1, 0, 0, 0, 1, 1, 1, L, 4, "R2 R3 linefill"); drain(0);
      start(1, 0, 1, 1, 0, 1, 1, 0, 0, 1, 1, 1, L, 4, "R6 ro code");     drain(2);
      start(1, 0, 0, 1, 0, 1, 1, 0, 0, 1, 1, 2, L, 1, "R6 ro data");     drain(1);
      start(1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 1, 2, L, 1, "R6 l2 only");     drain(0);
      start(1, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 3, 1, 1, "R4 no l2");       drain(0);
      start(1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 3, 1, 1, "R4 no ken");      drain(0);
      start(1, 0, 0, 1, 0, 1, 0, 1, 0, 1, 1, 3, 1, 1, "R4 locked");      drain(0);
      start(1, 0, 0, 1, 0, 1, 0, 0, 1, 0, 1, 3, 1, 1, "R4 pcd");         drain(0);
      start(1, 1, 0, 1, 0, 1, 0, 0, 0, 1, 1, 6, L, 0, "R5 replace");     drain(2);
      start(1, 1, 0, 0, 0, 1, 0, 0, 0, 1, 1, 5, 1, 1, "R5 write");       drain(0);
      start(1, 0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 4, L, 0, "R7 alloc");       drain(0);
      start(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8, 1, 0, "R7 io no rdy");   drain(1);
    end
    @(negedge clk);
    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule